// File: doc/BRIEF.md
# Register-indirect LPC access bridge

This block sits as a slave on a 64-bit register bus whose accesses are always full, 8-byte aligned words. Software reaches a byte-addressed downstream bus through two registers: a command word that carries direction, a 7-bit byte count and a 32-bit downstream address, and a data word. A downstream read is started by writing the command word with its direction bit set; the returned sector lands in the data word. A downstream write is started by writing the data word while the stored command has its direction bit clear.

Downstream data moves as a big-endian 8-byte sector. The byte at downstream address A sits in big-endian lane A mod 8 of the data word, so sub-word values are not right-justified: a read result is shifted right by 8 times the address offset, and on a write the data word is shifted left by the same amount so that its lane at the offset leaves first. A status word always reports done, and a handful of housekeeping indices are accepted and ignored. While a downstream transfer is in flight the upstream side is stalled.

Top module: `lpc_reg_bridge`

## Requirements
- R1: The register index is the upstream byte address shifted right by 3. An access whose byte address has bits [2:0] not all zero is accepted, reads zero and a write to it changes no register and starts nothing.
- R2: Index 0x41 (command) and index 0x42 (data) read back the last value stored in them.
- R3: Command bit 63 set means read, clear means write; the downstream address is command bits [31:0] and the byte count is command bits [58:52].
- R4: Writing the command with bit 63 set starts exactly one downstream read; downstream read data is big-endian (first byte in bits [63:56]) and, on the response, the data register takes that sector shifted right by 8 times address bits [2:0].
- R5: Writing the command with bit 63 clear stores it and starts no downstream transfer.
- R6: Writing the data register while the stored command has bit 63 clear starts one downstream write whose data is the new value shifted left by 8 times address bits [2:0]; while the stored command has bit 63 set, the write only stores the value.
- R7: Index 0x43 (status) always reads 64'h8000_0000_0000_0000; writes to it have no effect.
- R8: Index 0x40 (base), indices 0x12, 0x13, 0x18 and every other unlisted index read zero, and writes to them change neither the command nor the data register and start nothing.
- R9: From the access that starts a transfer until it completes (write: request handshake; read: response), upstream ready is low, and the downstream request stays valid with stable fields until accepted.
- R10: After reset the command and data registers are zero, no downstream request is pending and upstream ready is high, so a first data write starts a write to address 0 with byte count 0.
- R11: An accepted upstream read returns its data with a one-cycle response valid pulse in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Upstream access valid |
| req_ready_o | output | 1 | Upstream access accepted when high |
| req_write_i | input | 1 | Upstream access is a write |
| req_addr_i | input | UP_AW | Upstream byte address |
| req_wdata_i | input | 64 | Upstream write data |
| rsp_valid_o | output | 1 | Upstream read data valid |
| rsp_rdata_o | output | 64 | Upstream read data |
| dn_valid_o | output | 1 | Downstream request valid |
| dn_ready_i | input | 1 | Downstream request accepted |
| dn_write_o | output | 1 | Downstream request is a write |
| dn_addr_o | output | DN_AW | Downstream byte address |
| dn_size_o | output | SIZE_W | Downstream byte count |
| dn_wdata_o | output | 64 | Downstream write sector, first byte in bits [63:56] |
| dn_rvalid_i | input | 1 | Downstream read response valid |
| dn_rdata_i | input | 64 | Downstream read sector, first byte in bits [63:56] |

## Verification
The bench targets lane placement at a non-zero offset in both directions: a design that right-justified reads or shifted writes the wrong way returns or sends bytes in the wrong lanes. It checks that the data-register write respects the stored direction, since a design that launched on every data write would issue a spurious downstream write after a read command. Misaligned addresses, the status word and the ignored indices are each written with junk and read back through the command and data registers, which a loose decoder would corrupt. The default after reset is exercised by a first data write, which must go to address 0 with a zero byte count.

// File: rtl/lpc_bridge_pkg.sv
package lpc_bridge_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned OFF_W   = $clog2(LANES);
  localparam int unsigned IDX_BASE   = 'h40;
  localparam int unsigned IDX_CMD    = 'h41;
  localparam int unsigned IDX_DATA   = 'h42;
  localparam int unsigned IDX_STATUS = 'h43;
  localparam int unsigned DIR_BIT    = 63;
  localparam int unsigned SIZE_LSB   = 52;
  localparam logic [DATA_W-1:0] STATUS_VAL = {1'b1, {(DATA_W-1){1'b0}}};

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_CMD    = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/lpc_reg_decode.sv
module lpc_reg_decode
  import lpc_bridge_pkg::*;
#(
  parameter int unsigned UP_AW = 16
) (
  input  logic [UP_AW-1:0] addr_i,
  output reg_sel_e         sel_o
);
  localparam int unsigned IDX_W = UP_AW - 3;
  localparam int unsigned NHIT  = 3;
  localparam int unsigned HIT_IDX [NHIT] = '{IDX_CMD, IDX_DATA, IDX_STATUS};
  localparam reg_sel_e    HIT_SEL [NHIT] = '{SEL_CMD, SEL_DATA, SEL_STATUS};

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic [NHIT-1:0]  hit;

  assign idx     = addr_i[UP_AW-1:3];
  assign aligned = (addr_i[2:0] == 3'b000);

  for (genvar g = 0; g < NHIT; g++) begin : g_hit
    assign hit[g] = aligned && (idx == IDX_W'(HIT_IDX[g]));
  end

  always_comb begin
    sel_o = SEL_NONE;
    for (int i = 0; i < NHIT; i++) begin
      if (hit[i]) sel_o = HIT_SEL[i];
    end
  end

  // R1
  always_comb begin
    decode_onehot_chk: assert ($onehot0(hit));
  end
endmodule

// File: rtl/lpc_lane_steer.sv
module lpc_lane_steer
  import lpc_bridge_pkg::*;
(
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] rd_raw_i,
  input  logic [DATA_W-1:0] wr_src_i,
  output logic [DATA_W-1:0] rd_placed_o,
  output logic [DATA_W-1:0] wr_placed_o
);
  // big-endian lane l occupies bits [DATA_W-1-8l -: 8]
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned HI = DATA_W - 1 - 8 * l;
    always_comb begin
      rd_placed_o[HI -: 8] = '0;
      wr_placed_o[HI -: 8] = '0;
      for (int s = 0; s < LANES; s++) begin
        if (OFF_W'(s) == off_i) begin
          if (l >= s) rd_placed_o[HI -: 8] = rd_raw_i[DATA_W-1-8*(l-s) -: 8];
          if (l + s < LANES) wr_placed_o[HI -: 8] = wr_src_i[DATA_W-1-8*(l+s) -: 8];
        end
      end
    end
  end

  // R4
  always_comb begin
    if (off_i == '0) begin
      lane_pass_chk: assert (rd_placed_o == rd_raw_i && wr_placed_o == wr_src_i);
    end
  end
endmodule

// File: rtl/lpc_xfer_ctrl.sv
module lpc_xfer_ctrl
  import lpc_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cmd_i,
  input  logic              wr_data_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              dn_ready_i,
  input  logic              dn_rvalid_i,
  input  logic [DATA_W-1:0] rd_placed_i,
  output logic [DATA_W-1:0] cmd_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o,
  output logic              dn_valid_o
);
  xfer_state_e       state_q, state_d;
  logic [DATA_W-1:0] cmd_q, data_q;
  logic              launch_rd, launch_wr;

  assign launch_rd = wr_cmd_i && wdata_i[DIR_BIT];
  assign launch_wr = wr_data_i && !cmd_q[DIR_BIT];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (launch_rd || launch_wr) state_d = ST_REQ;
      ST_REQ:  if (dn_ready_i) state_d = cmd_q[DIR_BIT] ? ST_WAIT : ST_IDLE;
      ST_WAIT: if (dn_rvalid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (wr_cmd_i) cmd_q <= wdata_i;
      if (wr_data_i) data_q <= wdata_i;
      else if (state_q == ST_WAIT && dn_rvalid_i) data_q <= rd_placed_i;
    end
  end

  assign cmd_o      = cmd_q;
  assign data_o     = data_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign dn_valid_o = (state_q == ST_REQ);

  // R9
  dn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o && !dn_ready_i |=> dn_valid_o && $stable(cmd_q) && $stable(data_q));
  // R4
  data_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state_q == ST_WAIT && dn_rvalid_i) && !wr_data_i |=> $stable(data_q));
  // R5
  cmd_wr_nolaunch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE && wr_cmd_i && !wdata_i[DIR_BIT] && !wr_data_i |=> state_q == ST_IDLE);
endmodule

// File: rtl/lpc_reg_bridge.sv
module lpc_reg_bridge
  import lpc_bridge_pkg::*;
#(
  parameter int unsigned UP_AW  = 16,
  parameter int unsigned DN_AW  = 32,
  parameter int unsigned SIZE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [UP_AW-1:0]  req_addr_i,
  input  logic [63:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [63:0]       rsp_rdata_o,
  output logic              dn_valid_o,
  input  logic              dn_ready_i,
  output logic              dn_write_o,
  output logic [DN_AW-1:0]  dn_addr_o,
  output logic [SIZE_W-1:0] dn_size_o,
  output logic [63:0]       dn_wdata_o,
  input  logic              dn_rvalid_i,
  input  logic [63:0]       dn_rdata_i
);
  reg_sel_e          sel;
  logic              accept, busy;
  logic              wr_cmd, wr_data;
  logic [DATA_W-1:0] cmd_q, data_q, rd_placed, rd_mux;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic              rd_status_q;

  lpc_reg_decode #(.UP_AW(UP_AW)) u_decode (
    .addr_i (req_addr_i),
    .sel_o  (sel)
  );

  assign accept  = req_valid_i && req_ready_o;
  assign wr_cmd  = accept && req_write_i && (sel == SEL_CMD);
  assign wr_data = accept && req_write_i && (sel == SEL_DATA);

  lpc_xfer_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_cmd_i    (wr_cmd),
    .wr_data_i   (wr_data),
    .wdata_i     (req_wdata_i),
    .dn_ready_i  (dn_ready_i),
    .dn_rvalid_i (dn_rvalid_i),
    .rd_placed_i (rd_placed),
    .cmd_o       (cmd_q),
    .data_o      (data_q),
    .busy_o      (busy),
    .dn_valid_o  (dn_valid_o)
  );

  lpc_lane_steer u_lane (
    .off_i       (cmd_q[OFF_W-1:0]),
    .rd_raw_i    (dn_rdata_i),
    .wr_src_i    (data_q),
    .rd_placed_o (rd_placed),
    .wr_placed_o (dn_wdata_o)
  );

  assign req_ready_o = !busy;
  assign dn_write_o  = !cmd_q[DIR_BIT];
  assign dn_addr_o   = cmd_q[DN_AW-1:0];
  assign dn_size_o   = cmd_q[SIZE_LSB +: SIZE_W];

  always_comb begin
    unique case (sel)
      SEL_CMD:    rd_mux = cmd_q;
      SEL_DATA:   rd_mux = data_q;
      SEL_STATUS: rd_mux = STATUS_VAL;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rd_status_q <= 1'b0;
    end else begin
      rsp_valid_q <= accept && !req_write_i;
      rd_status_q <= accept && !req_write_i && (sel == SEL_STATUS);
      if (accept && !req_write_i) rsp_rdata_q <= rd_mux;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  // R9
  busy_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> !req_ready_o);
  // R7
  status_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rd_status_q |-> rsp_rdata_o == STATUS_VAL);
  // R11
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !req_write_i |=> rsp_valid_o);
  // R6
  wr_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data && dn_write_o |=> dn_valid_o && dn_write_o);
endmodule

// File: tb/lpc_reg_bridge_tb.sv
module lpc_reg_bridge_tb;
  localparam int unsigned UP_AW = 16;
  localparam logic [15:0] A_BASE = 16'h0200, A_CMD = 16'h0208, A_DATA = 16'h0210,
                          A_STAT = 16'h0218;
  localparam logic [63:0] STAT = 64'h8000_0000_0000_0000;

  logic clk_i = 0, rst_ni = 0;
  logic req_valid_i = 0, req_write_i = 0;
  logic [15:0] req_addr_i = '0;
  logic [63:0] req_wdata_i = '0;
  logic req_ready_o, rsp_valid_o, dn_valid_o, dn_write_o;
  logic [63:0] rsp_rdata_o, dn_wdata_o;
  logic [31:0] dn_addr_o;
  logic [6:0] dn_size_o;
  logic dn_ready_i = 0, dn_rvalid_i = 0;
  logic [63:0] dn_rdata_i = '0;

  int n_run = 0, n_fail = 0, n_req = 0;
  logic cap_wr, cap_stable;
  logic [31:0] cap_addr;
  logic [6:0] cap_size;
  logic [63:0] cap_wdata;

  always #2 clk_i = ~clk_i;

  lpc_reg_bridge #(.UP_AW(UP_AW)) u_dut (.*);

  function automatic logic [63:0] pat(input logic [31:0] a);
    return {a, a ^ 32'hA5A5_5A5A};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [63:0] d);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1; req_write_i = 1; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 0; req_write_i = 0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [63:0] d);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1; req_write_i = 0; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 0;
    chk("R11 rsp_valid", {63'd0, rsp_valid_o}, 64'd1);
    d = rsp_rdata_o;
  endtask

  task automatic wait_idle();
    while (!req_ready_o) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  // downstream responder
  initial forever begin
    @(negedge clk_i);
    if (dn_valid_o) begin
      cap_wr = dn_write_o; cap_addr = dn_addr_o; cap_size = dn_size_o; cap_wdata = dn_wdata_o;
      cap_stable = 1;
      repeat (2) begin
        @(negedge clk_i);
        if (!dn_valid_o || dn_addr_o != cap_addr || dn_wdata_o != cap_wdata) cap_stable = 0;
      end
      dn_ready_i = 1;
      @(negedge clk_i);
      dn_ready_i = 0;
      n_req++;
      if (!cap_wr) begin
        repeat (2) @(negedge clk_i);
        dn_rdata_i = pat(cap_addr); dn_rvalid_i = 1;
        @(negedge clk_i);
        dn_rvalid_i = 0;
      end
    end
  end

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [63:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, A_CMD,    64'h0070_0000_1234_5678, 8'd5},
    '{1'b0, A_CMD,    64'h0070_0000_1234_5678, 8'd2},
    '{1'b0, A_STAT,   STAT,                    8'd7},
    '{1'b1, A_STAT,   64'hDEAD_BEEF_0000_0001, 8'd7},
    '{1'b0, A_STAT,   STAT,                    8'd7},
    '{1'b0, A_BASE,   64'd0,                   8'd8},
    '{1'b1, A_BASE,   64'hFFFF_FFFF_FFFF_FFFF, 8'd8},
    '{1'b0, 16'h0090, 64'd0,                   8'd8},
    '{1'b1, 16'h0098, 64'h1111_2222_3333_4444, 8'd8},
    '{1'b0, 16'h00C0, 64'd0,                   8'd8},
    '{1'b0, 16'h02A8, 64'd0,                   8'd8},
    '{1'b1, 16'h0209, 64'h0123_4567_89AB_CDEF, 8'd1},
    '{1'b0, 16'h020A, 64'd0,                   8'd1},
    '{1'b0, A_CMD,    64'h0070_0000_1234_5678, 8'd8}
  };

  initial begin
    logic [63:0] d;
    int base_req;
    fork
      begin
        repeat (20000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog got timeout exp finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R10 reset state
    chk("R10 ready", {63'd0, req_ready_o}, 64'd1);
    chk("R10 dn_valid", {63'd0, dn_valid_o}, 64'd0);
    bus_rd(A_CMD, d);  chk("R10 cmd", d, 64'd0);
    bus_rd(A_DATA, d); chk("R10 data", d, 64'd0);

    // table walk: R1 R2 R5 R7 R8
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_wr(VEC[i].addr, VEC[i].data);
      else begin
        bus_rd(VEC[i].addr, d);
        chk($sformatf("R%0d vec%0d", VEC[i].req, i), d, VEC[i].data);
      end
    end
    repeat (8) @(negedge clk_i);
    chk("R5 R8 no launch", 64'(n_req), 64'd0);

    // R4 read at offset 3, size 4
    bus_wr(A_CMD, 64'h8040_0000_0000_1003);
    chk("R9 ready low", {63'd0, req_ready_o}, 64'd0);
    wait_idle();
    chk("R3 dir", {63'd0, cap_wr}, 64'd0);
    chk("R3 addr", {32'd0, cap_addr}, 64'h1003);
    chk("R3 size", {57'd0, cap_size}, 64'd4);
    chk("R9 stable", {63'd0, cap_stable}, 64'd1);
    bus_rd(A_DATA, d); chk("R4 placed off3", d, pat(32'h1003) >> 24);

    // R4 offset 0, size 8
    bus_wr(A_CMD, 64'h8080_0000_0000_2000);
    wait_idle();
    bus_rd(A_DATA, d); chk("R4 placed off0", d, pat(32'h2000));

    // R6 data write under read command: store only
    base_req = n_req;
    bus_wr(A_DATA, 64'hCAFE_F00D_0000_0042);
    repeat (8) @(negedge clk_i);
    chk("R6 no launch", 64'(n_req - base_req), 64'd0);
    bus_rd(A_DATA, d); chk("R6 stored", d, 64'hCAFE_F00D_0000_0042);

    // R6 write launch at offset 6, size 2
    bus_wr(A_CMD, 64'h0020_0000_0000_0046);
    repeat (4) @(negedge clk_i);
    chk("R5 no launch", 64'(n_req - base_req), 64'd0);
    bus_wr(A_DATA, 64'h1122_3344_5566_7788);
    chk("R9 ready low wr", {63'd0, req_ready_o}, 64'd0);
    wait_idle();
    chk("R6 launched", 64'(n_req - base_req), 64'd1);
    chk("R6 dir", {63'd0, cap_wr}, 64'd1);
    chk("R6 addr", {32'd0, cap_addr}, 64'h46);
    chk("R6 size", {57'd0, cap_size}, 64'd2);
    chk("R6 wdata", cap_wdata, 64'h7788_0000_0000_0000);

    // R10 default after reset: data write goes to addr 0 size 0
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    base_req = n_req;
    bus_wr(A_DATA, 64'h0102_0304_0506_0708);
    wait_idle();
    chk("R10 launched", 64'(n_req - base_req), 64'd1);
    chk("R10 dir", {63'd0, cap_wr}, 64'd1);
    chk("R10 addr", {32'd0, cap_addr}, 64'd0);
    chk("R10 size", {57'd0, cap_size}, 64'd0);
    chk("R10 wdata", cap_wdata, 64'h0102_0304_0506_0708);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule